// File: doc/BRIEF.md
# Bus Monitor Message Error Flagger

This block sits behind the word decoder of a monitor on a MIL-STD-1553 command/response bus. It watches the decoded words of one message and builds a status byte of error and condition flags for that message. Each decoded word arrives as a one-cycle strobe. The strobe carries:

- the sync type;
- the 16-bit word;
- a decoder error bit;
- a marker that says whether the word opens a terminal response (the first word after a bus gap).

The storage logic reports a buffer wrap as a separate pulse. The end of a message is marked by its own pulse.

The first word of a message is taken as the command. From the command the block reads the direction and the expected word count, and it counts the data words actually seen. It checks each word's sync against the party that sent it, and it inspects the terminal status word for set flag bits and for Busy. When the message ends, the block presents the byte together with a one-cycle done strobe. It then starts the next message clean.

Top module: `msg_err_flagger`

## Requirements
- R1: The first valid word of a message is its command. Command bit 10 set means transmit, and bits [4:0] give the expected word count, where 0 means 32. Valid words after the command with `w_rsp`=0 are data words. Flag bit 5 (length) is set when the data-word count differs from the expected count.
- R2: Bit 5 stays clear when the message holds a status word (`w_rsp`=1, after the command) received without decoder error whose bit 3 (Busy) is 1.
- R3: Bit 5 stays clear for a transmit command that received no status word (a response timeout). A receive command with no status word is still checked.
- R4: Flag bit 4 (sync type) is set in any of three cases. `w_csync`=1 means command/status sync and 0 means data sync. The cases are: a command with data sync, a data word with command/status sync, or a status word with data sync.
- R5: Flag bit 3 (invalid word) is set when any word of the message arrives with `w_err`=1.
- R6: Flag bit 6 (status set) is set when a status word received without decoder error has any of its bits [10:0] equal to 1. Bits [15:11] (terminal address) do not set it.
- R7: Flag bit 7 (rollover) is set when `wrap_evt` is high in any cycle of the message, up to and including the cycle of `msg_end`.
- R8: `done_o` is high for exactly the one cycle after a `msg_end` cycle. A word that arrives with `msg_end` belongs to the ending message. `flags_o` is updated in that same cycle and is held until the next done. Bits [2:0] are 0. The next message starts with no flags carried over.
- R9: After reset, `flags_o` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| w_vld | input | 1 | Decoded word strobe |
| w_csync | input | 1 | 1 = command/status sync, 0 = data sync |
| w_rsp | input | 1 | Word opens a terminal response (status word) |
| w_err | input | 1 | Decoder error: Manchester, bit count or parity |
| w_word | input | 16 | Decoded word |
| wrap_evt | input | 1 | Storage pointer wrapped to base for this message |
| msg_end | input | 1 | Last cycle of the message |
| done_o | output | 1 | Status byte valid strobe |
| flags_o | output | 8 | Message status byte |

## Verification
Two sets of events can fall in the same cycle. The first is the final word of a message arriving together with `msg_end`. The second is a buffer wrap coinciding with that end. The bench always puts the last word of every message in the `msg_end` cycle, so every length, sync, invalid-word and status result depends on the final word being folded into the byte. Separate runs place `wrap_evt` on the command cycle and on the ending cycle, and the rollover bit is expected in both.

// File: rtl/msg_err_flagger.sv
module msg_err_flagger #(
  parameter int CNT_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        w_vld,
  input  logic        w_csync,
  input  logic        w_rsp,
  input  logic        w_err,
  input  logic [15:0] w_word,
  input  logic        wrap_evt,
  input  logic        msg_end,
  output logic        done_o,
  output logic [7:0]  flags_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int TR_BIT   = 10;
  localparam int BUSY_BIT = 3;

  logic             in_msg, is_tx, busy_seen, stat_seen;
  logic             f_roll, f_ssf, f_sync, f_inv;
  logic [CNT_W-1:0] exp_cnt, dcnt;

  logic             cmd_slot, stat_slot, dat_slot, clean_stat;
  logic             n_in, n_tx, n_busy, n_stat, n_roll, n_ssf, n_sync, n_inv, len_bad;
  logic [CNT_W-1:0] n_exp, n_dcnt, wc_words;

  assign cmd_slot   = w_vld & ~in_msg;
  assign stat_slot  = w_vld & in_msg & w_rsp;
  assign dat_slot   = w_vld & in_msg & ~w_rsp;
  assign clean_stat = stat_slot & ~w_err;

  assign wc_words = (w_word[4:0] == 5'd0) ? CNT_W'(32) : CNT_W'(w_word[4:0]);

  assign n_in   = in_msg | cmd_slot;
  assign n_tx   = cmd_slot ? w_word[TR_BIT] : is_tx;
  assign n_exp  = cmd_slot ? wc_words : exp_cnt;
  assign n_dcnt = (dat_slot && dcnt != CNT_MAX) ? dcnt + 1'b1 : dcnt;
  assign n_busy = busy_seen | (clean_stat & w_word[BUSY_BIT]);
  assign n_stat = stat_seen | stat_slot;

  assign n_roll = f_roll | wrap_evt;
  assign n_ssf  = f_ssf  | (clean_stat & (|w_word[10:0]));
  assign n_inv  = f_inv  | (w_vld & w_err);
  assign n_sync = f_sync | (cmd_slot & ~w_csync) | (dat_slot & w_csync) | (stat_slot & ~w_csync);

  assign len_bad = n_in & (n_dcnt != n_exp) & ~n_busy & ~(n_tx & ~n_stat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      flags_o   <= '0;
      in_msg    <= 1'b0;
      is_tx     <= 1'b0;
      busy_seen <= 1'b0;
      stat_seen <= 1'b0;
      exp_cnt   <= '0;
      dcnt      <= '0;
      f_roll    <= 1'b0;
      f_ssf     <= 1'b0;
      f_sync    <= 1'b0;
      f_inv     <= 1'b0;
    end else if (msg_end) begin
      done_o    <= 1'b1;
      flags_o   <= {n_roll, n_ssf, len_bad, n_sync, n_inv, 3'b000};
      in_msg    <= 1'b0;
      is_tx     <= 1'b0;
      busy_seen <= 1'b0;
      stat_seen <= 1'b0;
      exp_cnt   <= '0;
      dcnt      <= '0;
      f_roll    <= 1'b0;
      f_ssf     <= 1'b0;
      f_sync    <= 1'b0;
      f_inv     <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      in_msg    <= n_in;
      is_tx     <= n_tx;
      busy_seen <= n_busy;
      stat_seen <= n_stat;
      exp_cnt   <= n_exp;
      dcnt      <= n_dcnt;
      f_roll    <= n_roll;
      f_ssf     <= n_ssf;
      f_sync    <= n_sync;
      f_inv     <= n_inv;
    end
  end

  p_done_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |=> done_o);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_end |=> !done_o);
  p_flags_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_end |=> $stable(flags_o));
  p_low_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[2:0] == 3'b000);
  p_wrap_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end && wrap_evt) |=> flags_o[7]);
  p_err_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end && w_vld && w_err) |=> flags_o[3]);
  p_busy_no_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end && w_vld && in_msg && w_rsp && !w_err && w_word[BUSY_BIT]) |=> !flags_o[5]);
endmodule

// File: tb/tb_msg_err_flagger.sv
module tb_msg_err_flagger;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic w_vld = 0, w_csync = 0, w_rsp = 0, w_err = 0, wrap_evt = 0, msg_end = 0;
  logic [15:0] w_word = '0;
  logic done_o;
  logic [7:0] flags_o;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  msg_err_flagger dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic cs, input logic rsp, input logic er,
                     input logic [15:0] wd, input logic wr, input logic en);
    @(negedge clk);
    w_vld = v; w_csync = cs; w_rsp = rsp; w_err = er; w_word = wd; wrap_evt = wr; msg_end = en;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 16'h0, 0, 0);
  endtask

  // slot codes: 0 none, 1 command, 2 data (first), 3 status
  // wrap_mode: 0 none, 1 on command cycle, 2 on ending cycle
  task automatic run_msg(input bit tx, input logic [4:0] wc, input int nd, input bit has_st,
                         input logic [15:0] st, input int sync_bad, input int err_slot,
                         input int wrap_mode, input string tag);
    int total, k, exp_n;
    bit len, ssf, st_err, last;
    logic [7:0] e;
    total = 1 + nd + (has_st ? 1 : 0);
    for (int i = 0; i < total; i++) begin
      last = (i == total - 1);
      if (i == 0)
        cyc(1, sync_bad != 1, 0, err_slot == 1, {5'd3, tx, 5'd1, wc},
            wrap_mode == 1 || (last && wrap_mode == 2), last);
      else if (has_st && ((tx && i == 1) || (!tx && i == total - 1)))
        cyc(1, sync_bad != 3, 1, err_slot == 3, st, last && wrap_mode == 2, last);
      else begin
        k = tx ? i - 1 - (has_st ? 1 : 0) : i - 1;
        cyc(1, (sync_bad == 2 && k == 0), 0, (err_slot == 2 && k == 0),
            16'hA500 + 16'(k), last && wrap_mode == 2, last);
      end
    end
    idle();
    exp_n  = (wc == 0) ? 32 : int'(wc);
    st_err = has_st && err_slot == 3;
    len = (nd != exp_n) && !(has_st && !st_err && st[3]) && !(tx && !has_st);
    ssf = has_st && !st_err && (st[10:0] != 0);
    e = {wrap_mode != 0, ssf, len,
         (sync_bad == 1) || (sync_bad == 3 && has_st) || (sync_bad == 2 && nd > 0),
         (err_slot == 1) || (err_slot == 3 && has_st) || (err_slot == 2 && nd > 0), 3'b000};
    chk({7'b0, done_o}, 8'h01, {tag, " done"});
    chk(flags_o, e, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(flags_o, 8'h00, "R9 flags at reset");
    chk({7'b0, done_o}, 8'h00, "R9 done at reset");
    rst_n = 1'b1;
    idle();

    for (int tx = 0; tx < 2; tx++)
      for (int wc = 0; wc < 32; wc++)
        for (int d = -1; d <= 1; d++)
          run_msg(tx[0], wc[4:0], ((wc == 0) ? 32 : wc) + d, 1, 16'h1800, 0, 0, 0, "R1 length sweep");

    run_msg(0, 5'd5, 3, 1, 16'h1808, 0, 0, 0, "R2 busy suppresses");
    run_msg(1, 5'd5, 7, 1, 16'h1808, 0, 0, 0, "R2 busy suppresses tx");
    run_msg(0, 5'd5, 3, 1, 16'h1808, 0, 3, 0, "R2 busy with decoder error");

    run_msg(1, 5'd4, 0, 0, 16'h0, 0, 0, 0, "R3 tx timeout");
    run_msg(1, 5'd0, 0, 0, 16'h0, 0, 0, 0, "R3 tx timeout count 32");
    run_msg(0, 5'd4, 2, 0, 16'h0, 0, 0, 0, "R3 rx no status still checked");

    for (int tx = 0; tx < 2; tx++)
      for (int s = 1; s <= 3; s++) begin
        run_msg(tx[0], 5'd3, 3, 1, 16'h1800, s, 0, 0, "R4 sync type");
        run_msg(tx[0], 5'd3, 3, 1, 16'h1800, 0, s, 0, "R5 invalid word");
      end

    for (int b = 0; b < 16; b++)
      run_msg(0, 5'd2, 2, 1, 16'(1) << b, 0, 0, 0, "R6 status bit");

    run_msg(0, 5'd2, 2, 1, 16'h1800, 0, 0, 1, "R7 wrap on command");
    run_msg(1, 5'd2, 2, 1, 16'h1800, 0, 0, 2, "R7 wrap on end cycle");
    run_msg(1, 5'd2, 2, 1, 16'h1800, 0, 0, 0, "R8 clean after wrap");

    run_msg(0, 5'd1, 0, 1, 16'h1801, 2, 1, 2, "R8 mixed");
    idle();
    chk({7'b0, done_o}, 8'h00, "R8 done single cycle");
    chk(flags_o, 8'he8, "R8 flags held");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule